// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit sits at the end of a word-addressed integer pipeline. It chooses the address of the next instruction. It takes two register operands A and D, a 3-bit condition code and the current program counter. It subtracts D from A once to get the zero, negative, overflow and carry flags. It decides from those flags whether a conditional branch is taken. It also handles two unconditional transfers: a register-relative jump, and a jump-and-link whose target is the sum of two registers and an immediate.

The instruction decoder drives the unit. The decoder raises one of three enables (branch, jump, jump-and-link) and supplies offsets that are already sign-extended to the address width. The unit returns three values, all held in a result register one clock after the inputs are presented:
- the next program counter,
- a redirect flag,
- the link value. The register file writes the link value back when the instruction is a jump-and-link.

All address arithmetic wraps modulo 2^AW. A branch with a zero offset targets itself, which is how an idle loop is built.

Top module: `bpc_unit`

## Requirements
- R1: While rst_n is low, next_pc_o, taken_o and link_o are all zero.
- R2: Condition 3'b000 (equal) is taken when A equals D. Condition 3'b001 (not equal) is taken when they differ.
- R3: Condition 3'b010 (unsigned lower) is taken when there is a borrow, meaning the carry out of A + ~D + 1 is 0. Condition 3'b011 (unsigned higher or same) is taken when that carry is 1.
- R4: Condition 3'b100 (signed less) is taken when N differs from V. Condition 3'b101 (signed greater or equal) is taken when N equals V. This must also hold when the subtraction overflows.
- R5: Conditions 3'b110 and 3'b111 are never taken. The next PC is then PC+1.
- R6: A taken branch sets next_pc_o to PC + br_off_i modulo 2^AW and raises taken_o. A zero offset yields the current PC.
- R7: With no enable raised, or with a branch not taken, next_pc_o is PC+1 modulo 2^AW (0xFFFFFF wraps to 0) and taken_o is 0.
- R8: A jump sets next_pc_o to A + tgt_off_i and raises taken_o. A is zero-extended to AW bits first.
- R9: A jump-and-link sets next_pc_o to A + B + tgt_off_i and raises taken_o. Both registers are zero-extended to AW bits first.
- R10: When several enables are raised, jump-and-link wins over jump, and jump wins over branch.
- R11: link_o is PC+1 modulo 2^AW for every input pattern.
- R12: Each output reflects the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_en_i | input | 1 | Conditional branch request |
| jmp_en_i | input | 1 | Register-relative jump request |
| lnk_en_i | input | 1 | Jump-and-link request |
| cond_i | input | 3 | Condition code |
| opa_i | input | XLEN | Register operand A |
| opd_i | input | XLEN | Register operand D, the value compared against A |
| opb_i | input | XLEN | Register operand B, the index for jump-and-link |
| br_off_i | input | AW | Sign-extended branch offset |
| tgt_off_i | input | AW | Sign-extended immediate for jump and jump-and-link |
| pc_i | input | AW | Current program counter |
| next_pc_o | output | AW | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| link_o | output | AW | PC+1, the return address |

## Verification
The hardest case to reach from the ports is a signed compare whose subtraction overflows. Here the negative flag alone gives the wrong answer, and only the overflow correction decides the result. The stimulus reaches it with operands at opposite ends of the signed range: the most negative value minus 1, and the most positive value minus -1. Both are checked against signed less and signed greater-or-equal. Other pairs are placed where the unsigned and signed orders disagree, and at the equal boundary of greater-or-equal. Address wrap is reached by running sequential and negative-offset cases from PC values near 0 and near 2^AW-1.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

   typedef enum logic [2:0] {
      CND_EQ   = 3'b000,
      CND_NE   = 3'b001,
      CND_LTU  = 3'b010,
      CND_GEU  = 3'b011,
      CND_LT   = 3'b100,
      CND_GE   = 3'b101,
      CND_RSV6 = 3'b110,
      CND_RSV7 = 3'b111
   } cond_e;

   typedef struct packed {
      logic z;
      logic n;
      logic v;
      logic c;
   } flags_t;

   typedef enum logic [1:0] {
      SEL_SEQ  = 2'b00,
      SEL_BR   = 2'b01,
      SEL_JMP  = 2'b10,
      SEL_JALR = 2'b11
   } sel_e;

endpackage

// File: rtl/bpc_flags.sv
module bpc_flags
   import bpc_pkg::*;
#(
   parameter int XLEN = 16
) (
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opd_i,
   output flags_t          flags_o
);
   localparam int MSB = XLEN - 1;

   logic [XLEN:0] diff;

   // A + ~D + 1: the top bit is the carry, which is 1 when no borrow occurs
   assign diff = {1'b0, opa_i} + {1'b0, ~opd_i} + {{XLEN{1'b0}}, 1'b1};

   always_comb begin
      flags_o.c = diff[XLEN];
      flags_o.z = (diff[MSB:0] == '0);
      flags_o.n = diff[MSB];
      flags_o.v = (opa_i[MSB] != opd_i[MSB]) && (diff[MSB] != opa_i[MSB]);
   end

endmodule

// File: rtl/bpc_cond_eval.sv
module bpc_cond_eval
   import bpc_pkg::*;
(
   input  flags_t     flags_i,
   input  logic [2:0] cond_i,
   output logic       hit_o
);
   cond_e cnd;
   assign cnd = cond_e'(cond_i);

   always_comb begin
      unique case (cnd)
         CND_EQ:   hit_o =  flags_i.z;
         CND_NE:   hit_o = ~flags_i.z;
         CND_LTU:  hit_o = ~flags_i.c;
         CND_GEU:  hit_o =  flags_i.c;
         CND_LT:   hit_o =  flags_i.n ^ flags_i.v;
         CND_GE:   hit_o = ~(flags_i.n ^ flags_i.v);
         CND_RSV6,
         CND_RSV7: hit_o = 1'b0;
         default:  hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/bpc_target.sv
module bpc_target
   import bpc_pkg::*;
#(
   parameter int XLEN = 16,
   parameter int AW   = 24
) (
   input  logic [AW-1:0]   pc_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   input  logic [AW-1:0]   br_off_i,
   input  logic [AW-1:0]   tgt_off_i,
   input  sel_e            sel_i,
   output logic [AW-1:0]   next_pc_o,
   output logic [AW-1:0]   link_o
);
   logic [AW-1:0] opa_w;
   logic [AW-1:0] opb_w;
   logic [AW-1:0] pc_inc;
   logic [AW-1:0] jmp_base;

   // Fit register values to the address width: zero-extend or truncate
   generate
      if (XLEN >= AW) begin : g_trunc
         assign opa_w = opa_i[AW-1:0];
         assign opb_w = opb_i[AW-1:0];
      end else begin : g_zext
         localparam int PAD = AW - XLEN;
         assign opa_w = {{PAD{1'b0}}, opa_i};
         assign opb_w = {{PAD{1'b0}}, opb_i};
      end
   endgenerate

   assign pc_inc = pc_i + {{(AW-1){1'b0}}, 1'b1};
   assign link_o = pc_inc;

   // Jump and jump-and-link share one adder. Only the index term differs.
   assign jmp_base = (sel_i == SEL_JALR) ? (opa_w + opb_w) : opa_w;

   always_comb begin
      unique case (sel_i)
         SEL_BR:            next_pc_o = pc_i + br_off_i;
         SEL_JMP, SEL_JALR: next_pc_o = jmp_base + tgt_off_i;
         default:           next_pc_o = pc_inc;
      endcase
   end

endmodule

// File: rtl/bpc_unit.sv
module bpc_unit
   import bpc_pkg::*;
#(
   parameter int XLEN      = 16,
   parameter int AW        = 24,
   parameter int OUT_STAGE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_en_i,
   input  logic            jmp_en_i,
   input  logic            lnk_en_i,
   input  logic [2:0]      cond_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opd_i,
   input  logic [XLEN-1:0] opb_i,
   input  logic [AW-1:0]   br_off_i,
   input  logic [AW-1:0]   tgt_off_i,
   input  logic [AW-1:0]   pc_i,
   output logic [AW-1:0]   next_pc_o,
   output logic            taken_o,
   output logic [AW-1:0]   link_o
);
   // Elaboration-time parameter checks
   generate
      if (XLEN < 2) begin : g_bad_xlen
         $error("bpc_unit: XLEN must be at least 2");
      end
      if (AW < 2) begin : g_bad_aw
         $error("bpc_unit: AW must be at least 2");
      end
      if (OUT_STAGE != 0 && OUT_STAGE != 1) begin : g_bad_stage
         $error("bpc_unit: OUT_STAGE must be 0 or 1");
      end
   endgenerate

   flags_t        flg;
   logic          cond_hit;
   sel_e          sel;
   logic [AW-1:0] npc_c;
   logic [AW-1:0] link_c;
   logic          taken_c;

   bpc_flags #(.XLEN(XLEN)) u_flags (
      .opa_i   (opa_i),
      .opd_i   (opd_i),
      .flags_o (flg)
   );

   bpc_cond_eval u_cond (
      .flags_i (flg),
      .cond_i  (cond_i),
      .hit_o   (cond_hit)
   );

   // Priority: jump-and-link, then jump, then conditional branch
   always_comb begin
      if (lnk_en_i)                 sel = SEL_JALR;
      else if (jmp_en_i)            sel = SEL_JMP;
      else if (br_en_i && cond_hit) sel = SEL_BR;
      else                          sel = SEL_SEQ;
   end

   assign taken_c = (sel != SEL_SEQ);

   bpc_target #(.XLEN(XLEN), .AW(AW)) u_tgt (
      .pc_i      (pc_i),
      .opa_i     (opa_i),
      .opb_i     (opb_i),
      .br_off_i  (br_off_i),
      .tgt_off_i (tgt_off_i),
      .sel_i     (sel),
      .next_pc_o (npc_c),
      .link_o    (link_c)
   );

   generate
      if (OUT_STAGE == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               next_pc_o <= '0;
               taken_o   <= 1'b0;
               link_o    <= '0;
            end else begin
               next_pc_o <= npc_c;
               taken_o   <= taken_c;
               link_o    <= link_c;
            end
         end
      end else begin : g_comb
         assign next_pc_o = rst_n ? npc_c   : '0;
         assign taken_o   = rst_n & taken_c;
         assign link_o    = rst_n ? link_c  : '0;
      end
   endgenerate

endmodule

// File: rtl/bpc_unit_chk.sv
module bpc_unit_chk #(
   parameter int XLEN      = 16,
   parameter int AW        = 24,
   parameter int OUT_STAGE = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            br_en_i,
   input logic            jmp_en_i,
   input logic            lnk_en_i,
   input logic [2:0]      cond_i,
   input logic [XLEN-1:0] opa_i,
   input logic [XLEN-1:0] opd_i,
   input logic [XLEN-1:0] opb_i,
   input logic [AW-1:0]   br_off_i,
   input logic [AW-1:0]   tgt_off_i,
   input logic [AW-1:0]   pc_i,
   input logic [AW-1:0]   next_pc_o,
   input logic            taken_o,
   input logic [AW-1:0]   link_o
);
   logic [AW-1:0] pc_inc;
   logic [AW-1:0] br_tgt;
   logic          br_only;

   assign pc_inc  = pc_i + {{(AW-1){1'b0}}, 1'b1};
   assign br_tgt  = pc_i + br_off_i;
   assign br_only = br_en_i && !jmp_en_i && !lnk_en_i;

   generate
      if (OUT_STAGE == 1) begin : g_seq
         // R2: equal operands under condition 000 redirect to the branch target
         a_r2_eq_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (br_only && cond_i == 3'b000 && opa_i == opd_i)
            |=> (taken_o && next_pc_o == $past(br_tgt)));

         // R3: an unsigned lower operand under condition 010 is taken
         a_r3_ltu_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (br_only && cond_i == 3'b010 && opa_i < opd_i) |=> taken_o);

         // R4: a signed lower operand under condition 100 is taken
         a_r4_lt_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (br_only && cond_i == 3'b100 && $signed(opa_i) < $signed(opd_i)) |=> taken_o);

         // R5: reserved codes never redirect
         a_r5_rsv_never: assert property (@(posedge clk) disable iff (!rst_n)
            (br_only && cond_i[2:1] == 2'b11) |=> (!taken_o && next_pc_o == $past(pc_inc)));

         // R7: no enable means fall-through
         a_r7_seq: assert property (@(posedge clk) disable iff (!rst_n)
            (!br_en_i && !jmp_en_i && !lnk_en_i)
            |=> (!taken_o && next_pc_o == $past(pc_inc)));

         // R9: jump-and-link always redirects
         a_r9_jalr_taken: assert property (@(posedge clk) disable iff (!rst_n)
            lnk_en_i |=> taken_o);

         // R11: the link value tracks the previous PC
         a_r11_link: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (link_o == $past(pc_inc)));
      end
   endgenerate

endmodule

bind bpc_unit bpc_unit_chk #(
   .XLEN(XLEN), .AW(AW), .OUT_STAGE(OUT_STAGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .br_en_i   (br_en_i),
   .jmp_en_i  (jmp_en_i),
   .lnk_en_i  (lnk_en_i),
   .cond_i    (cond_i),
   .opa_i     (opa_i),
   .opd_i     (opd_i),
   .opb_i     (opb_i),
   .br_off_i  (br_off_i),
   .tgt_off_i (tgt_off_i),
   .pc_i      (pc_i),
   .next_pc_o (next_pc_o),
   .taken_o   (taken_o),
   .link_o    (link_o)
);

// File: tb/sim_bpc_unit.sv
module sim_bpc_unit;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 16;
   localparam int AW   = 24;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            br_en, jmp_en, lnk_en;
   logic [2:0]      cond;
   logic [XLEN-1:0] opa, opd, opb;
   logic [AW-1:0]   br_off, tgt_off, pc;
   logic [AW-1:0]   next_pc, link;
   logic            taken;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bpc_unit #(.XLEN(XLEN), .AW(AW), .OUT_STAGE(1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .br_en_i(br_en), .jmp_en_i(jmp_en), .lnk_en_i(lnk_en),
      .cond_i(cond), .opa_i(opa), .opd_i(opd), .opb_i(opb),
      .br_off_i(br_off), .tgt_off_i(tgt_off), .pc_i(pc),
      .next_pc_o(next_pc), .taken_o(taken), .link_o(link)
   );

   function automatic logic [AW-1:0] zx(input logic [XLEN-1:0] v);
      return {{(AW-XLEN){1'b0}}, v};
   endfunction

   // Reference taken decision, computed directly from the operand order
   function automatic logic ref_hit(input logic [2:0] c, input logic [XLEN-1:0] a,
                                    input logic [XLEN-1:0] d);
      case (c)
         3'b000:  return a == d;
         3'b001:  return a != d;
         3'b010:  return a < d;
         3'b011:  return a >= d;
         3'b100:  return $signed(a) < $signed(d);
         3'b101:  return $signed(a) >= $signed(d);
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] e_pc,
                        input logic e_tk, input logic [AW-1:0] e_lk);
      n_chk++;
      if (next_pc !== e_pc || taken !== e_tk || link !== e_lk) begin
         n_fail++;
         $display("FAIL %s: next_pc=%h taken=%b link=%h expected next_pc=%h taken=%b link=%h",
                  tag, next_pc, taken, link, e_pc, e_tk, e_lk);
      end
   endtask

   // Drive at the falling edge, let one rising edge register it (R12), sample at the next falling edge
   task automatic run(input string tag, input logic b, input logic j, input logic l,
                      input logic [2:0] c, input logic [XLEN-1:0] a, input logic [XLEN-1:0] d,
                      input logic [XLEN-1:0] bx, input logic [AW-1:0] bo,
                      input logic [AW-1:0] to, input logic [AW-1:0] p);
      logic [AW-1:0] e_pc;
      logic          e_tk;
      @(negedge clk);
      br_en = b; jmp_en = j; lnk_en = l; cond = c;
      opa = a; opd = d; opb = bx; br_off = bo; tgt_off = to; pc = p;
      if (l) begin
         e_pc = zx(a) + zx(bx) + to; e_tk = 1'b1;
      end else if (j) begin
         e_pc = zx(a) + to; e_tk = 1'b1;
      end else if (b && ref_hit(c, a, d)) begin
         e_pc = p + bo; e_tk = 1'b1;
      end else begin
         e_pc = p + 24'd1; e_tk = 1'b0;
      end
      @(negedge clk);
      check(tag, e_pc, e_tk, p + 24'd1);
   endtask

   task automatic t_reset;
      br_en = 0; jmp_en = 0; lnk_en = 0; cond = 0;
      opa = 0; opd = 0; opb = 0; br_off = 0; tgt_off = 0; pc = 24'h000ABC;
      repeat (3) @(negedge clk);
      check("R1 reset state", '0, 1'b0, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_eq_ne;
      run("R2 beq equal",     1,0,0, 3'b000, 16'h0005, 16'h0005, 0, 24'h10, 0, 24'h100);
      run("R2 beq differ",    1,0,0, 3'b000, 16'h0005, 16'h0006, 0, 24'h10, 0, 24'h100);
      run("R2 bne differ",    1,0,0, 3'b001, 16'h1234, 16'h1235, 0, 24'h20, 0, 24'h200);
      run("R2 bne equal",     1,0,0, 3'b001, 16'hFFFF, 16'hFFFF, 0, 24'h20, 0, 24'h200);
   endtask

   task automatic t_unsigned;
      run("R3 bltu small<big", 1,0,0, 3'b010, 16'h0001, 16'hFFFF, 0, 24'h8, 0, 24'h300);
      run("R3 bltu big",       1,0,0, 3'b010, 16'hFFFF, 16'h0001, 0, 24'h8, 0, 24'h300);
      run("R3 bgeu big",       1,0,0, 3'b011, 16'hFFFF, 16'h0001, 0, 24'h8, 0, 24'h300);
      run("R3 bgeu equal",     1,0,0, 3'b011, 16'h4000, 16'h4000, 0, 24'h8, 0, 24'h300);
   endtask

   task automatic t_signed;
      run("R4 blt overflow min-1", 1,0,0, 3'b100, 16'h8000, 16'h0001, 0, 24'h4, 0, 24'h400);
      run("R4 bge overflow min-1", 1,0,0, 3'b101, 16'h8000, 16'h0001, 0, 24'h4, 0, 24'h400);
      run("R4 bge overflow max+1", 1,0,0, 3'b101, 16'h7FFF, 16'hFFFF, 0, 24'h4, 0, 24'h400);
      run("R4 blt overflow max+1", 1,0,0, 3'b100, 16'h7FFF, 16'hFFFF, 0, 24'h4, 0, 24'h400);
      run("R4 blt neg<pos",        1,0,0, 3'b100, 16'hFFFE, 16'h0003, 0, 24'h4, 0, 24'h400);
      run("R4 bge equal",          1,0,0, 3'b101, 16'h8000, 16'h8000, 0, 24'h4, 0, 24'h400);
   endtask

   task automatic t_reserved;
      run("R5 code 110 equal", 1,0,0, 3'b110, 16'h0007, 16'h0007, 0, 24'h40, 0, 24'h500);
      run("R5 code 110 less",  1,0,0, 3'b110, 16'h0001, 16'h0007, 0, 24'h40, 0, 24'h500);
      run("R5 code 111 equal", 1,0,0, 3'b111, 16'h0007, 16'h0007, 0, 24'h40, 0, 24'h500);
      run("R5 code 111 less",  1,0,0, 3'b111, 16'h8000, 16'h0007, 0, 24'h40, 0, 24'h500);
   endtask

   task automatic t_offsets;
      run("R6 zero offset self loop", 1,0,0, 3'b000, 16'h0000, 16'h0000, 0, 24'h000000, 0, 24'h002000);
      run("R6 negative offset wrap",  1,0,0, 3'b000, 16'h0000, 16'h0000, 0, 24'hFFFFF8, 0, 24'h000005);
      run("R6 positive offset wrap",  1,0,0, 3'b001, 16'h0001, 16'h0000, 0, 24'h000010, 0, 24'hFFFFF8);
   endtask

   task automatic t_sequential;
      run("R7 idle step",       0,0,0, 3'b000, 16'h0003, 16'h0003, 0, 24'h50, 0, 24'h000600);
      run("R7 idle wrap R11",   0,0,0, 3'b000, 16'h0000, 16'h0000, 0, 24'h50, 0, 24'hFFFFFF);
   endtask

   task automatic t_jump;
      run("R8 jump plus",       0,1,0, 3'b000, 16'h1234, 16'h0000, 0, 0, 24'h000010, 24'h700);
      run("R8 jump zero-ext",   0,1,0, 3'b000, 16'hFFFF, 16'h0000, 0, 0, 24'hFFFFFF, 24'h700);
   endtask

   task automatic t_jalr;
      run("R9 jalr sum link R11", 0,0,1, 3'b000, 16'h0100, 16'h0000, 16'h0020, 0, 24'h000003, 24'h800);
      run("R9 jalr wide sum",     0,0,1, 3'b000, 16'hFFFF, 16'h0000, 16'hFFFF, 0, 24'hFFFFFE, 24'hFFFFFF);
   endtask

   task automatic t_priority;
      run("R10 jalr over jump and branch", 1,1,1, 3'b000, 16'h0010, 16'h0010, 16'h0001, 24'h99, 24'h2, 24'h900);
      run("R10 jump over taken branch",    1,1,0, 3'b000, 16'h0010, 16'h0010, 16'h0001, 24'h99, 24'h2, 24'h900);
   endtask

   task automatic t_latency;
      // R12: back-to-back inputs, each result appears one cycle later
      run("R12 first of pair",  1,0,0, 3'b000, 16'h0001, 16'h0001, 0, 24'h7, 0, 24'hA00);
      run("R12 second of pair", 0,0,0, 3'b000, 16'h0001, 16'h0001, 0, 24'h7, 0, 24'hB00);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_eq_ne();
      t_unsigned();
      t_signed();
      t_reserved();
      t_offsets();
      t_sequential();
      t_jump();
      t_jalr();
      t_priority();
      t_latency();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule